// File: doc/BRIEF.md
# Dual-Order Serial Register Port

This block is a slave serial control port. It lets an external microcontroller write and read a bank of byte-wide internal registers over four wires: an active-low chip select, a serial clock, a serial data input and a serial data output. The port oversamples all three inputs in the local clock domain through a short synchronizer. It then works from the detected serial clock edges.

Each chip-select frame opens with one command byte. That byte fixes the direction (read or write) and the register address for the whole frame. Every byte that follows is data for that same register, up to the point where chip select returns high. A static mode input picks the serial bit order for every byte of the frame: least-significant first or most-significant first. The field positions inside the command byte do not depend on the mode. The full register contents are also presented on a flat output bus, for the logic the registers control.

Top module: `serial_regport`

## Requirements
- R1: While `rst_n` is low, every register goes to zero and `sdo` is 0.
- R2: After chip select falls, the first 8 rising serial clock edges form the command byte. In that byte, bit 0 is the direction (1 = read, 0 = write) and bits 5:1 are the register address. Bits 7:6 have no effect.
- R3: With `lsb_first` = 1, bit 0 of each command and data byte is shifted in first and shifted out first.
- R4: With `lsb_first` = 0, bit 7 of each command and data byte is shifted in first and shifted out first.
- R5: In a write frame, a data byte is stored in the addressed register only when that byte's 8th rising edge occurs. This holds even when chip select is released in the clock cycle right after that edge. A byte left incomplete by chip select going high changes no register.
- R6: Every data byte in a frame after the command uses the same address. Extra write bytes overwrite the same register, and extra read bytes return the same register again.
- R7: In a read frame, the first data bit appears on `sdo` after the falling serial clock edge that follows the 8th command bit. Later bits change only on falling edges. Data shifted in during a read never changes a register.
- R8: `sdo` is 0 while chip select is high, during the command byte, and throughout a write frame.
- R9: Chip select high clears the bit count and the frame state. A new command byte is accepted only after chip select goes high and then low again, so a byte that looks like a command in the middle of a frame is treated as data. An aborted command byte changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsb_first | input | 1 | Bit order select: 1 = LSB first, 0 = MSB first; static during a frame |
| cs_n | input | 1 | Active-low chip select from the master |
| sclk | input | 1 | Serial clock from the master, idle low |
| sdi | input | 1 | Serial data from the master, sampled on rising edges |
| sdo | output | 1 | Serial data to the master, updated on falling edges |
| regs_o | output | NREG*DW | All registers packed, register n at bits n*DW +: DW |

## Verification
Two functions can fall in the same local clock cycle. One is the register-write commit triggered by the 8th rising edge of a data byte. The other is the frame clear caused by chip select going high. The bench provokes this by releasing chip select one local clock after the final rising serial edge, before any falling edge. It judges the result by the register value on `regs_o` and by a readback through the port. A second overlap is the output-shifter reload at a byte boundary against the next falling edge. Multi-byte reads that must return the same register twice with the correct bit order cover that case.

// File: rtl/srp_pkg.sv
package srp_pkg;
   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } srp_phase_e;

   localparam int unsigned CMD_DIR_BIT  = 0;
   localparam int unsigned CMD_ADDR_LSB = 1;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int unsigned CHAIN_W = STAGES * WIDTH;

   if (STAGES < 2) begin : g_bad_stages
      $error("srp_sync: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], async_i};
      end
   end

   assign sync_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/srp_regbank.sv
module srp_regbank #(
   parameter int unsigned DW   = 8,
   parameter int unsigned AW   = 5,
   parameter logic [DW-1:0] RST_VAL = '0,
   localparam int unsigned NREG = 1 << AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [DW-1:0]      rd_data,
   output logic [NREG*DW-1:0] regs_o
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RST_VAL;
         end else if (wr_en && (wr_addr == AW'(i))) begin
            q <= wr_data;
         end
      end
      assign regs_o[i*DW +: DW] = q;
   end

   assign rd_data = regs_o[rd_addr*DW +: DW];
endmodule

// File: rtl/srp_frame.sv
module srp_frame
   import srp_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 5,
   localparam int unsigned CW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lsb_first,
   input  logic          cs_s,
   input  logic          sclk_s,
   input  logic          sdi_s,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] addr,
   output logic          wr_en,
   output logic [DW-1:0] wr_data,
   output logic          rd_mode,
   output logic          sclk_rise,
   output logic          sclk_fall,
   output logic          sdo
);
   logic          sclk_q;
   logic [CW-1:0] bit_cnt;
   srp_phase_e    phase;
   logic [DW-1:0] rx_sh;
   logic [DW-1:0] rx_next;
   logic [DW-1:0] tx_sh;
   logic [DW-1:0] tx_next;
   logic          tx_bit;
   logic          load_pend;
   logic          last_bit;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;
   assign last_bit  = (bit_cnt == CW'(DW - 1));

   always_comb begin
      if (lsb_first) begin
         rx_next = {sdi_s, rx_sh[DW-1:1]};
         tx_bit  = tx_sh[0];
         tx_next = {1'b0, tx_sh[DW-1:1]};
      end else begin
         rx_next = {rx_sh[DW-2:0], sdi_s};
         tx_bit  = tx_sh[DW-1];
         tx_next = {tx_sh[DW-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         bit_cnt   <= '0;
         phase     <= PH_CMD;
         rd_mode   <= 1'b0;
         addr      <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         load_pend <= 1'b0;
         sdo       <= 1'b0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
      end else begin
         sclk_q <= sclk_s;
         wr_en  <= 1'b0;
         if (cs_s) begin
            bit_cnt   <= '0;
            phase     <= PH_CMD;
            rd_mode   <= 1'b0;
            addr      <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            load_pend <= 1'b0;
            sdo       <= 1'b0;
         end else begin
            if (load_pend) begin
               tx_sh     <= rd_data;
               load_pend <= 1'b0;
            end
            if (sclk_rise) begin
               rx_sh   <= rx_next;
               bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
               if (last_bit) begin
                  if (phase == PH_CMD) begin
                     phase     <= PH_DATA;
                     rd_mode   <= rx_next[CMD_DIR_BIT];
                     addr      <= rx_next[CMD_ADDR_LSB +: AW];
                     load_pend <= rx_next[CMD_DIR_BIT];
                  end else if (rd_mode) begin
                     load_pend <= 1'b1;
                  end else begin
                     wr_en   <= 1'b1;
                     wr_data <= rx_next;
                  end
               end
            end
            if (sclk_fall) begin
               if ((phase == PH_DATA) && rd_mode) begin
                  sdo   <= tx_bit;
                  tx_sh <= tx_next;
               end else begin
                  sdo <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/serial_regport.sv
module serial_regport #(
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [DW-1:0] RST_VAL   = '0,
   localparam int unsigned NREG = 1 << AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lsb_first,
   input  logic               cs_n,
   input  logic               sclk,
   input  logic               sdi,
   output logic               sdo,
   output logic [NREG*DW-1:0] regs_o
);
   if (DW < AW + 1) begin : g_bad_width
      $error("serial_regport: command byte cannot hold direction and address");
   end
   if (DW < 2) begin : g_bad_dw
      $error("serial_regport: DW must be at least 2");
   end

   logic          cs_s;
   logic          sclk_s;
   logic          sdi_s;
   logic [AW-1:0] addr;
   logic          wr_en;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   logic          rd_mode;
   logic          sclk_rise;
   logic          sclk_fall;

   srp_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (3),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i({cs_n, sclk, sdi}),
      .sync_o ({cs_s, sclk_s, sdi_s})
   );

   srp_frame #(
      .DW(DW),
      .AW(AW)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .lsb_first(lsb_first),
      .cs_s     (cs_s),
      .sclk_s   (sclk_s),
      .sdi_s    (sdi_s),
      .rd_data  (rd_data),
      .addr     (addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_mode  (rd_mode),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .sdo      (sdo)
   );

   srp_regbank #(
      .DW     (DW),
      .AW     (AW),
      .RST_VAL(RST_VAL)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(addr),
      .wr_data(wr_data),
      .rd_addr(addr),
      .rd_data(rd_data),
      .regs_o (regs_o)
   );
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
   parameter int unsigned RW = 256
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_s,
   input logic          sclk_rise,
   input logic          sclk_fall,
   input logic          rd_mode,
   input logic          wr_en,
   input logic          sdo,
   input logic [RW-1:0] regs_o
);
   p_sdo_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s)) |-> !sdo);

   p_sdo_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> $past(sclk_fall || cs_s));

   p_wr_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(sclk_rise));

   p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   p_no_wr_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rd_mode);

   p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_o));

   p_no_wr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s)) |-> !wr_en);
endmodule

bind serial_regport srp_checker #(.RW(NREG * DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_s     (cs_s),
   .sclk_rise(sclk_rise),
   .sclk_fall(sclk_fall),
   .rd_mode  (rd_mode),
   .wr_en    (wr_en),
   .sdo      (sdo),
   .regs_o   (regs_o)
);

// File: tb/serial_regport_tb.sv
module serial_regport_tb;
   localparam int HALF  = 8;
   localparam int NVEC  = 8;
   localparam int WDOG  = 150000;

   // {lsb_first, address, data}
   localparam logic [13:0] VEC [NVEC] = '{
      {1'b1, 5'd0,  8'hA5},
      {1'b0, 5'd31, 8'h3C},
      {1'b1, 5'd1,  8'h80},
      {1'b0, 5'd2,  8'h01},
      {1'b1, 5'd16, 8'hFF},
      {1'b0, 5'd17, 8'h96},
      {1'b1, 5'd30, 8'h4B},
      {1'b0, 5'd5,  8'hE1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         lsb_first = 1'b1;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic         sdi = 1'b0;
   logic         sdo;
   logic [255:0] regs_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   serial_regport u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .lsb_first(lsb_first),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .sdo      (sdo),
      .regs_o   (regs_o)
   );

   function automatic logic [7:0] reg_at(input int a);
      return regs_o[a*8 +: 8];
   endfunction

   function automatic logic [7:0] cmd_byte(input logic rd, input logic [4:0] a);
      return {2'b00, a, rd};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cs_low();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_high();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (4 * HALF) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [7:0] tx, input int n,
                             output logic [7:0] rx, output bit saw_hi);
      rx = '0;
      saw_hi = 1'b0;
      for (int i = 0; i < n; i++) begin
         int idx;
         idx = lsb_first ? i : 7 - i;
         sdi = tx[idx];
         repeat (HALF) @(negedge clk);
         rx[idx] = sdo;
         if (sdo) saw_hi = 1'b1;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic write_frame(input logic [4:0] a, input logic [7:0] d, output bit hi);
      logic [7:0] rx;
      bit h1;
      bit h2;
      cs_low();
      shift_bits(cmd_byte(1'b0, a), 8, rx, h1);
      shift_bits(d, 8, rx, h2);
      cs_high();
      hi = h1 | h2;
   endtask

   task automatic read_frame(input logic [4:0] a, input logic [7:0] junk,
                             output logic [7:0] got, output bit cmd_hi);
      logic [7:0] rx;
      cs_low();
      shift_bits(cmd_byte(1'b1, a), 8, rx, cmd_hi);
      shift_bits(junk, 8, got, cmd_hi);
      cs_high();
   endtask

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] got;
      logic [7:0] rx;
      bit hi;
      bit hi2;

      repeat (4) @(negedge clk);
      // R1: reset state
      chk(regs_o == '0, "R1 regs zero in reset", regs_o[15:0], 16'h0);
      chk(sdo == 1'b0, "R1 sdo low in reset", {15'b0, sdo}, 16'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // Vector table: write then read back in both orders (R2, R3, R4, R7, R8)
      for (int v = 0; v < NVEC; v++) begin
         logic       m;
         logic [4:0] a;
         logic [7:0] d;
         {m, a, d} = VEC[v];
         lsb_first = m;
         write_frame(a, d, hi);
         chk(reg_at(a) == d, m ? "R3 write lsb-first" : "R4 write msb-first",
             {8'h0, reg_at(a)}, {8'h0, d});
         chk(!hi, "R8 sdo low during write frame", {15'b0, hi}, 16'h0);
         read_frame(a, 8'h00, got, hi);
         chk(got == d, m ? "R3 read lsb-first" : "R4 read msb-first",
             {8'h0, got}, {8'h0, d});
         lsb_first = ~m;
         read_frame(a, 8'h00, got, hi);
         chk(got == d, "R7 read in other order", {8'h0, got}, {8'h0, d});
      end
      chk(sdo == 1'b0, "R8 sdo low with cs high", {15'b0, sdo}, 16'h0);

      // R2: bits 7:6 of the command are ignored
      lsb_first = 1'b1;
      cs_low();
      shift_bits({2'b11, 5'd12, 1'b0}, 8, rx, hi);
      shift_bits(8'h5D, 8, rx, hi);
      cs_high();
      chk(reg_at(12) == 8'h5D, "R2 unused command bits ignored", {8'h0, reg_at(12)}, 16'h005D);

      // R6: several write bytes hit one address
      lsb_first = 1'b0;
      cs_low();
      shift_bits(cmd_byte(1'b0, 5'd7), 8, rx, hi);
      shift_bits(8'h11, 8, rx, hi);
      shift_bits(8'h22, 8, rx, hi);
      shift_bits(8'h33, 8, rx, hi);
      cs_high();
      chk(reg_at(7) == 8'h33, "R6 burst write same address", {8'h0, reg_at(7)}, 16'h0033);
      chk(reg_at(8) == 8'h00, "R6 neighbour untouched", {8'h0, reg_at(8)}, 16'h0000);

      // R5: partial data byte discarded
      cs_low();
      shift_bits(cmd_byte(1'b0, 5'd7), 8, rx, hi);
      shift_bits(8'hC4, 5, rx, hi);
      cs_high();
      chk(reg_at(7) == 8'h33, "R5 partial byte discarded", {8'h0, reg_at(7)}, 16'h0033);

      // R9: aborted command changes nothing; next frame decodes fresh
      lsb_first = 1'b1;
      cs_low();
      shift_bits(cmd_byte(1'b0, 5'd9), 4, rx, hi);
      cs_high();
      write_frame(5'd9, 8'h77, hi);
      chk(reg_at(9) == 8'h77, "R9 fresh command after abort", {8'h0, reg_at(9)}, 16'h0077);
      chk(reg_at(8) == 8'h00, "R9 aborted command no write", {8'h0, reg_at(8)}, 16'h0000);

      // R9: a command-like byte inside a frame is data
      cs_low();
      shift_bits(cmd_byte(1'b0, 5'd10), 8, rx, hi);
      shift_bits(8'h12, 8, rx, hi);
      shift_bits(cmd_byte(1'b1, 5'd11), 8, rx, hi);
      cs_high();
      chk(reg_at(10) == 8'h17, "R9 mid-frame command is data", {8'h0, reg_at(10)}, 16'h0017);

      // R7 and R6: read with junk input, two bytes from the same register
      lsb_first = 1'b0;
      cs_low();
      shift_bits(cmd_byte(1'b1, 5'd7), 8, rx, hi);
      chk(!hi, "R8 sdo low during command", {15'b0, hi}, 16'h0);
      shift_bits(8'hFF, 8, got, hi);
      chk(got == 8'h33, "R7 first read byte", {8'h0, got}, 16'h0033);
      shift_bits(8'hFF, 8, got, hi2);
      chk(got == 8'h33, "R6 second read byte same register", {8'h0, got}, 16'h0033);
      cs_high();
      chk(reg_at(7) == 8'h33, "R7 read input ignored", {8'h0, reg_at(7)}, 16'h0033);

      // R5: chip select released one clock after the final rising edge
      lsb_first = 1'b1;
      cs_low();
      shift_bits(cmd_byte(1'b0, 5'd20), 8, rx, hi);
      shift_bits(8'hB9, 7, rx, hi);
      sdi = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      @(negedge clk);
      cs_n = 1'b1;
      sclk = 1'b0;
      repeat (4 * HALF) @(negedge clk);
      chk(reg_at(20) == 8'hB9, "R5 commit with fast release", {8'h0, reg_at(20)}, 16'h00B9);
      read_frame(5'd20, 8'h00, got, hi);
      chk(got == 8'hB9, "R5 readback after fast release", {8'h0, got}, 16'h00B9);

      // R1: reset mid-run clears registers
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(regs_o == '0, "R1 regs zero after reset", regs_o[15:0], 16'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule